// File: doc/BRIEF.md
# Conditional Load-Immediate Execute Unit

This unit decodes and executes a small group of custom 32-bit instructions. Each instruction compares a first source register with a second operand. The second operand is either another register or a 5-bit immediate taken from the instruction word. When the comparison holds, the destination register receives a 5-bit signed constant, also taken from the instruction word and sign-extended. When it does not hold, the destination keeps the value it had.

The destination register is both an operand and the result. For that reason the unit receives the current destination value together with the two source values. It always writes back a result: either the constant, or the old destination value unchanged. The pipeline around it presents an instruction word with a valid strobe and the three register read values. One clock later it receives a write-back value, a write enable, the destination index and an illegal-instruction flag. Fetch, the register file, hazards and trap entry belong to the surrounding core.

Top module: `condli_unit`

## Requirements
- R1: While reset is high and on the first sampling point after it, out_valid, out_wen and out_illegal are 0.
- R2: Every output is registered. An instruction presented with in_valid high produces its result one clock later. A cycle with in_valid low produces out_valid, out_wen and out_illegal all 0 one clock later.
- R3: The instruction is recognised by opcode bits [6:0] = 1011011. The other fields are: rd in [11:7], condition code in [14:12], rs1 in [19:15], rs2 or compare immediate in [24:20], operand-select code in [26:25] (01 = register operand, 11 = immediate operand) and the load constant in [31:27].
- R4: Condition code 000 holds when the operands are equal. Condition code 001 holds when they differ.
- R5: Condition code 100 holds when rs1 is less than the operand as signed 32-bit numbers. Condition code 101 holds when it is greater than or equal, also signed.
- R6: Condition codes 110 and 111 are the unsigned less-than and greater-or-equal. In the immediate form, bits [24:20] are zero-extended (0 to 31) for these two codes.
- R7: In the immediate form with condition codes 000, 001, 100 or 101, bits [24:20] are sign-extended (-16 to 15) before the compare.
- R8: When a legal condition holds, out_wen is 1, out_rd equals bits [11:7], and out_wdata is bits [31:27] sign-extended to 32 bits.
- R9: When a legal condition does not hold, out_wen is still 1 and out_wdata equals the in_rd_val that was presented.
- R10: Operand-select codes 00 and 10 are illegal.
- R11: Condition codes 010 and 011 are illegal.
- R12: A zero rd or rs1 field is illegal, and so is a zero rs2 field in the register form. In the immediate form a zero in bits [24:20] is a legal immediate of 0.
- R13: Any opcode other than 1011011 is illegal.
- R14: An illegal instruction gives out_illegal = 1, out_wen = 0, out_wdata = 0 and out_rd = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| in_instr | input | 32 | Instruction word |
| in_rd_val | input | XLEN | Current value of the destination register |
| in_rs1_val | input | XLEN | Value of the first source register |
| in_rs2_val | input | XLEN | Value of the second source register |
| out_valid | output | 1 | A result is present this cycle |
| out_wen | output | 1 | Register write enable |
| out_illegal | output | 1 | The instruction was not a legal member of the group |
| out_rd | output | 5 | Destination register index |
| out_wdata | output | XLEN | Write-back value |

## Verification
The bench builds the unit with XLEN = 32 and the default shared-subtractor comparator. With that width, the signed and unsigned edge values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit exactly at the boundaries where the signed and unsigned orderings disagree. The subtractor's extra sign bit is therefore exercised for every sign combination. The immediate forms reach the extremes -16, 15 and 31, and zero-extension and sign-extension give different operands for the same bit pattern. The direct-comparator variant is not reached by these parameter values.

// File: rtl/condli_pkg.sv
package condli_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 7;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 5;

  localparam logic [OPC_W-1:0] OPC_GROUP = 7'b1011011;
  localparam logic [1:0]       SEL_REG   = 2'b01;
  localparam logic [1:0]       SEL_IMM   = 2'b11;

  typedef enum logic {
    CMP_EQUALITY = 1'b0,
    CMP_ORDER    = 1'b1
  } cmp_kind_e;

  typedef struct packed {
    logic             legal;
    logic             imm_form;
    cmp_kind_e        kind;
    logic             is_unsigned;
    logic             invert;
    logic [REG_W-1:0] rd_idx;
  } dec_t;

endpackage

// File: rtl/condli_decode.sv
module condli_decode
  import condli_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic [XLEN-1:0]    cmp_imm,
  output logic [XLEN-1:0]    load_val
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] f_rd;
  logic [REG_W-1:0] f_rs1;
  logic [REG_W-1:0] f_rs2;
  logic [2:0]       f_cond;
  logic [1:0]       f_sel;
  logic [IMM_W-1:0] f_load;

  logic opc_ok;
  logic sel_ok;
  logic cond_ok;
  logic regs_ok;
  logic unsigned_cmp;

  assign opc    = instr[6:0];
  assign f_rd   = instr[11:7];
  assign f_cond = instr[14:12];
  assign f_rs1  = instr[19:15];
  assign f_rs2  = instr[24:20];
  assign f_sel  = instr[26:25];
  assign f_load = instr[31:27];

  always_comb begin
    opc_ok       = (opc == OPC_GROUP);
    sel_ok       = (f_sel == SEL_REG) || (f_sel == SEL_IMM);
    cond_ok      = !(f_cond == 3'b010 || f_cond == 3'b011);
    regs_ok      = (f_rd != '0) && (f_rs1 != '0) &&
                   ((f_sel == SEL_IMM) || (f_rs2 != '0));
    unsigned_cmp = f_cond[2] & f_cond[1];

    dec.legal       = opc_ok & sel_ok & cond_ok & regs_ok;
    dec.imm_form    = (f_sel == SEL_IMM);
    dec.kind        = f_cond[2] ? CMP_ORDER : CMP_EQUALITY;
    dec.is_unsigned = unsigned_cmp;
    dec.invert      = f_cond[0];
    dec.rd_idx      = f_rd;

    if (unsigned_cmp) begin
      cmp_imm = {{EXT_W{1'b0}}, f_rs2};
    end else begin
      cmp_imm = {{EXT_W{f_rs2[IMM_W-1]}}, f_rs2};
    end
    load_val = {{EXT_W{f_load[IMM_W-1]}}, f_load};
  end

endmodule

// File: rtl/condli_compare.sv
module condli_compare
  import condli_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  cmp_kind_e       kind,
  input  logic            is_unsigned,
  input  logic            invert,
  output logic            hit
);

  logic is_eq;
  logic is_lt;
  logic base;

  assign is_eq = (op_a == op_b);

  generate
    if (SHARED_SUB) begin : g_sub
      logic [XLEN:0] ext_a;
      logic [XLEN:0] ext_b;
      logic [XLEN:0] diff;
      always_comb begin
        ext_a = {(~is_unsigned) & op_a[XLEN-1], op_a};
        ext_b = {(~is_unsigned) & op_b[XLEN-1], op_b};
        diff  = ext_a - ext_b;
      end
      assign is_lt = diff[XLEN];
    end else begin : g_direct
      logic lt_s;
      logic lt_u;
      assign lt_s  = ($signed(op_a) < $signed(op_b));
      assign lt_u  = (op_a < op_b);
      assign is_lt = is_unsigned ? lt_u : lt_s;
    end
  endgenerate

  assign base = (kind == CMP_ORDER) ? is_lt : is_eq;
  assign hit  = base ^ invert;

endmodule

// File: rtl/condli_outreg.sv
module condli_outreg
  import condli_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             legal,
  input  logic             hit,
  input  logic [XLEN-1:0]  load_val,
  input  logic [XLEN-1:0]  old_rd,
  input  logic [REG_W-1:0] rd_idx,
  output logic             out_valid,
  output logic             out_wen,
  output logic             out_illegal,
  output logic [REG_W-1:0] out_rd,
  output logic [XLEN-1:0]  out_wdata
);

  logic accept;
  assign accept = in_valid & legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_wdata   <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= accept;
      out_illegal <= in_valid & ~legal;
      out_rd      <= accept ? rd_idx : '0;
      if (accept) begin
        out_wdata <= hit ? load_val : old_rd;
      end else begin
        out_wdata <= '0;
      end
    end
  end

endmodule

// File: rtl/condli_unit.sv
module condli_unit
  import condli_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [XLEN-1:0]    in_rd_val,
  input  logic [XLEN-1:0]    in_rs1_val,
  input  logic [XLEN-1:0]    in_rs2_val,
  output logic               out_valid,
  output logic               out_wen,
  output logic               out_illegal,
  output logic [REG_W-1:0]   out_rd,
  output logic [XLEN-1:0]    out_wdata
);

  dec_t            dec;
  logic [XLEN-1:0] cmp_imm;
  logic [XLEN-1:0] load_val;
  logic [XLEN-1:0] second_op;
  logic            hit;

  condli_decode #(.XLEN(XLEN)) u_decode (
    .instr    (in_instr),
    .dec      (dec),
    .cmp_imm  (cmp_imm),
    .load_val (load_val)
  );

  assign second_op = dec.imm_form ? cmp_imm : in_rs2_val;

  condli_compare #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_compare (
    .op_a        (in_rs1_val),
    .op_b        (second_op),
    .kind        (dec.kind),
    .is_unsigned (dec.is_unsigned),
    .invert      (dec.invert),
    .hit         (hit)
  );

  condli_outreg #(.XLEN(XLEN)) u_outreg (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .legal       (dec.legal),
    .hit         (hit),
    .load_val    (load_val),
    .old_rd      (in_rd_val),
    .rd_idx      (dec.rd_idx),
    .out_valid   (out_valid),
    .out_wen     (out_wen),
    .out_illegal (out_illegal),
    .out_rd      (out_rd),
    .out_wdata   (out_wdata)
  );

endmodule

// File: rtl/condli_checker.sv
module condli_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     in_instr,
  input logic [XLEN-1:0] in_rd_val,
  input logic            out_valid,
  input logic            out_wen,
  input logic            out_illegal,
  input logic [XLEN-1:0] out_wdata
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> (!out_valid && !out_wen && !out_illegal)); // R2

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst)) |-> out_valid); // R2

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wen && out_valid && out_wdata == '0)); // R14

  AST_TAKEN_VALUE: assert property (@(posedge clk) disable iff (rst)
    (out_wen && out_wdata != $past(in_rd_val)) |->
      (out_wdata == {{(XLEN-5){$past(in_instr[31])}}, $past(in_instr[31:27])})); // R8

  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_instr[6:0]) != 7'b1011011) |-> out_illegal); // R13

  AST_BAD_COND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_instr[14:13]) == 2'b01) |-> out_illegal); // R11

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_instr[11:7]) == 5'd0) |-> out_illegal); // R12

  AST_BAD_SELECT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_instr[25]) == 1'b0) |-> out_illegal); // R10

endmodule

bind condli_unit condli_checker #(.XLEN(XLEN)) i_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .in_rd_val   (in_rd_val),
  .out_valid   (out_valid),
  .out_wen     (out_wen),
  .out_illegal (out_illegal),
  .out_wdata   (out_wdata)
);

// File: tb/test_condli_unit.sv
`timescale 1ns/1ps
module test_condli_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rd_val = '0;
  logic [31:0] in_rs1_val = '0;
  logic [31:0] in_rs2_val = '0;
  logic        out_valid;
  logic        out_wen;
  logic        out_illegal;
  logic [4:0]  out_rd;
  logic [31:0] out_wdata;

  int n_checks = 0;
  int n_bad    = 0;

  always #2.5 clk = ~clk;

  condli_unit #(.XLEN(32), .SHARED_SUB(1'b1)) i_condli_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_rd_val(in_rd_val), .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val),
    .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_wdata(out_wdata)
  );

  localparam logic [6:0] OPC = 7'b1011011;

  function automatic logic [31:0] mk(input logic [4:0] ld, input logic [1:0] sel,
                                     input logic [4:0] r2, input logic [4:0] r1,
                                     input logic [2:0] cc, input logic [4:0] rd,
                                     input logic [6:0] opc);
    return {ld, sel, r2, r1, cc, rd, opc};
  endfunction

  function automatic bit ref_legal(input logic [31:0] ins);
    if (ins[6:0] != OPC) return 0;
    if (ins[26:25] != 2'b01 && ins[26:25] != 2'b11) return 0;
    if (ins[14:12] == 3'b010 || ins[14:12] == 3'b011) return 0;
    if (ins[11:7] == 0 || ins[19:15] == 0) return 0;
    if (ins[26:25] == 2'b01 && ins[24:20] == 0) return 0;
    return 1;
  endfunction

  function automatic bit ref_hit(input logic [31:0] ins, input logic [31:0] a,
                                 input logic [31:0] r2v);
    logic [31:0] b;
    logic [2:0]  cc;
    cc = ins[14:12];
    if (ins[26:25] == 2'b11) begin
      if (cc == 3'b110 || cc == 3'b111) b = {27'd0, ins[24:20]};
      else b = {{27{ins[24]}}, ins[24:20]};
    end else b = r2v;
    case (cc)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      default: return a >= b;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    if (ins[6:0] != OPC) return "R13";
    if (ins[26:25] != 2'b01 && ins[26:25] != 2'b11) return "R10";
    if (ins[14:12] == 3'b010 || ins[14:12] == 3'b011) return "R11";
    if (!ref_legal(ins)) return "R12";
    if (ins[14] == 1'b0) return (ins[26:25] == 2'b11) ? "R7" : "R4";
    if (ins[13] == 1'b0) return (ins[26:25] == 2'b11) ? "R7" : "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] rdv,
                     input logic [31:0] a, input logic [31:0] r2v);
    bit legal;
    bit hit;
    logic [31:0] exp_data;
    string t;
    in_valid = 1'b1; in_instr = ins; in_rd_val = rdv;
    in_rs1_val = a; in_rs2_val = r2v;
    legal = ref_legal(ins);
    hit   = ref_hit(ins, a, r2v);
    t     = tag_of(ins);
    if (!legal) exp_data = '0;
    else if (hit) exp_data = {{27{ins[31]}}, ins[31:27]};
    else exp_data = rdv;
    @(negedge clk);
    chk("R2", {63'd0, out_valid}, 64'd1);
    if (!legal) begin
      chk({t, "/R14"}, {25'd0, out_illegal, out_wen, out_rd, out_wdata},
          {25'd0, 1'b1, 1'b0, 5'd0, 32'd0});
    end else begin
      chk({t, hit ? "/R8" : "/R9"}, {25'd0, out_illegal, out_wen, out_rd, out_wdata},
          {25'd0, 1'b0, 1'b1, ins[11:7], exp_data});
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_instr = $urandom();
    @(negedge clk);
    chk("R2", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
  endtask

  logic [31:0] edges [4];
  logic [4:0]  imms  [4];
  logic [2:0]  conds [6];

  initial begin
    edges[0] = 32'h0000_0000; edges[1] = 32'h7FFF_FFFF;
    edges[2] = 32'h8000_0000; edges[3] = 32'hFFFF_FFFF;
    imms[0] = 5'd0; imms[1] = 5'd15; imms[2] = 5'h10; imms[3] = 5'h1F;
    conds[0] = 3'b000; conds[1] = 3'b001; conds[2] = 3'b100;
    conds[3] = 3'b101; conds[4] = 3'b110; conds[5] = 3'b111;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    idle();

    // R3 R4 R5 R6: every condition, register form, edge pairs
    for (int c = 0; c < 6; c++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run(mk(5'h13, 2'b01, 5'd6, 5'd4, conds[c], 5'd2, OPC),
              32'hA5A5_0000 + 32'(i*4+j), edges[i], edges[j]);

    // R6 R7: every condition, immediate form, edge values against extreme immediates
    for (int c = 0; c < 6; c++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run(mk(5'h0F, 2'b11, imms[j], 5'd9, conds[c], 5'd17, OPC),
              32'h1234_5600 + 32'(i), edges[i], 32'hDEAD_BEEF);

    // R7: 0xFFFFFFFF equals sign-extended 0x1F; R6: not zero-extended 31
    run(mk(5'h01, 2'b11, 5'h1F, 5'd3, 3'b000, 5'd5, OPC), 32'h55, 32'hFFFF_FFFF, 0);
    run(mk(5'h01, 2'b11, 5'h1F, 5'd3, 3'b110, 5'd5, OPC), 32'h55, 32'd30, 0);
    run(mk(5'h01, 2'b11, 5'h1F, 5'd3, 3'b110, 5'd5, OPC), 32'h55, 32'd31, 0);

    // R10 R11 R12 R13 R14
    run(mk(5'h02, 2'b00, 5'd6, 5'd4, 3'b000, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b10, 5'd6, 5'd4, 3'b000, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b01, 5'd6, 5'd4, 3'b010, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b11, 5'd6, 5'd4, 3'b011, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b01, 5'd6, 5'd4, 3'b000, 5'd0, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b01, 5'd6, 5'd0, 3'b000, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b01, 5'd0, 5'd4, 3'b000, 5'd2, OPC), 32'h7, 32'd1, 32'd1);
    run(mk(5'h02, 2'b11, 5'd0, 5'd4, 3'b000, 5'd2, OPC), 32'h7, 32'd0, 32'd9);
    run(mk(5'h02, 2'b01, 5'd6, 5'd4, 3'b000, 5'd2, 7'b0001011), 32'h7, 32'd1, 32'd1);
    idle();

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      if (($urandom() % 12) == 0) idle();
      if (($urandom() % 8) == 0) ins = $urandom();
      else begin
        ins = mk(5'($urandom()), ($urandom() % 4 == 0) ? 2'($urandom()) : 2'b01 | 2'({$urandom() % 2, 1'b0}),
                 5'($urandom()), 5'($urandom()), conds[$urandom() % 6],
                 5'($urandom()), ($urandom() % 16 == 0) ? 7'($urandom()) : OPC);
      end
      a = ($urandom() % 2) ? edges[$urandom() % 4] : $urandom();
      case ($urandom() % 4)
        0: b = a;
        1: b = edges[$urandom() % 4];
        2: b = {{27{ins[24]}}, ins[24:20]};
        default: b = $urandom();
      endcase
      if (($urandom() % 3) == 0) a = {{27{ins[24]}}, ins[24:20]} + 32'($urandom() % 3) - 32'd1;
      run(ins, $urandom(), a, b);
    end
    idle();

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule